// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one channel of a general-purpose timer. Software programs a start count and a 32-bit control word. While the channel is enabled, a down counter is decremented once per prescaled tick. The tick rate is the reference clock divided by the prescale field plus one. When the count runs out, the channel emits a one-cycle expiry pulse. In periodic mode it reloads the start count and keeps running. In one-shot mode it stops and drops both its enable and its active indication.

The surrounding wrapper decodes the bus and owns the interrupt status flag. It hands this channel write strobes with data for the two writable registers and reads back the control word, the start count and the live count. The channel exports its interrupt-enable bit so the wrapper can gate the flag.

Control is built around a two-state machine. IDLE means the counter is frozen. RUN means it counts. The transitions are:
- start: a control write with the enable bit set, moving IDLE to RUN.
- stop: a control write with the enable bit clear, moving RUN to IDLE.
- expire-in-one-shot: the count runs out with periodic mode off, moving RUN to IDLE.

Top module: `dtmr_channel`

## Requirements
- R1: After reset, the control read value is 0x00000005 (prescale field 5, all flags clear). The start count and the live count both read 0, and the expiry pulse is low.
- R2: Control bits 24:8 and bit 25 ignore written values. Bits 24:8 always read 0. Bit 25 (active) reads 1 exactly while the channel is in RUN.
- R3: A write to the start-count register loads that value into both the start-count register and the live counter in the same clock edge, and restarts the prescaler phase.
- R4: In RUN, the count decrements once every (prescale+1) reference clocks. The prescale field is control bits 7:0. With count N and prescale P, the expiry pulse `zero_o` is high for the cycle that follows the N*(P+1)-th clock edge after the enabling write.
- R5: One-shot expiry (control bit 27 = 0) leaves the count at 0 and clears control bits 30 (enable) and 25 (active).
- R6: Periodic expiry (control bit 27 = 1) reloads the start count and continues, giving a pulse every N*(P+1) clocks.
- R7: Writing control bit 30 = 0 enters IDLE, clears bit 25, and freezes the count at the value it had before that write. Writing bit 30 = 1 resumes counting from the frozen value with a fresh prescaler phase.
- R8: Writing control bit 26 (counter reset) reloads the count from the start-count register. Bit 26 always reads 0. If bits 26 and 30 are written set together, the enable is dropped.
- R9: A control write that changes the prescale field keeps the current count. The next decrement comes a full new period later.
- R10: Output `irq_en_o` follows control bit 29, and control bit 27 reads back the written periodic select.
- R11: When a start-count write or a counter reset lands on the same edge as a tick, the write wins. The count takes the written value, no expiry is signalled, and the channel stays in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control register write data |
| load_wr_i | input | 1 | Start-count register write strobe |
| load_wdata_i | input | DW | Start-count write data |
| ctrl_rdata_o | output | 32 | Control register read value |
| load_rdata_o | output | DW | Start-count register read value |
| count_o | output | DW | Live down-counter value |
| zero_o | output | 1 | One-cycle expiry pulse |
| irq_en_o | output | 1 | Interrupt enable bit for the wrapper |

## Verification
Expiry of the count and a software reload (a start-count write or a counter reset) can fall on the same clock edge. This is provoked by timing a start-count write onto the exact edge on which the last tick of a one-shot count is due. The scoreboard judges the result by three things:
- no expiry pulse appears at that edge;
- the count reads the newly written value and the channel is still active;
- a single expiry arrives exactly the new count's worth of ticks later.

A prescale change placed one edge before a pending tick is judged in the same way, by the cycle of the next pulse.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int CTRL_W    = 32;
    localparam int EN_BIT    = 30;
    localparam int IE_BIT    = 29;
    localparam int PER_BIT   = 27;
    localparam int CRST_BIT  = 26;
    localparam int ACT_BIT   = 25;
    localparam int PS_W      = 8;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0000_0005;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
    parameter int PSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic           clr_i,
    input  logic [PSW-1:0] div_i,
    output logic           tick_o
);
    logic [PSW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr_i || !run_i || (phase_q == div_i)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o = run_i && !clr_i && (phase_q == div_i);
endmodule

// File: rtl/dtmr_fsm.sv
module dtmr_fsm
    import dtmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       done_i,
    output logic       running_o
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)          state_d = ST_RUN;
            ST_RUN:  if (stop_i || done_i) state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        running_o = (state_q == ST_RUN);
    end
endmodule

// File: rtl/dtmr_ctrl_reg.sv
module dtmr_ctrl_reg
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              done_i,
    input  logic              act_i,
    output logic              en_o,
    output logic              ie_o,
    output logic              per_o,
    output logic [PS_W-1:0]   ps_o,
    output logic [CTRL_W-1:0] rdata_o
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[31], wdata_i[28], wdata_i[ACT_BIT:PS_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o  <= CTRL_RESET[EN_BIT];
            ie_o  <= CTRL_RESET[IE_BIT];
            per_o <= CTRL_RESET[PER_BIT];
            ps_o  <= CTRL_RESET[PS_W-1:0];
        end else begin
            if (wr_i) begin
                ie_o  <= wdata_i[IE_BIT];
                per_o <= wdata_i[PER_BIT];
                ps_o  <= wdata_i[PS_W-1:0];
            end
            if (done_i)    en_o <= 1'b0;
            else if (wr_i) en_o <= wdata_i[EN_BIT] & ~wdata_i[CRST_BIT];
        end
    end

    always_comb begin
        rdata_o            = '0;
        rdata_o[EN_BIT]    = en_o;
        rdata_o[IE_BIT]    = ie_o;
        rdata_o[PER_BIT]   = per_o;
        rdata_o[ACT_BIT]   = act_i;
        rdata_o[PS_W-1:0]  = ps_o;
    end
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              load_wr_i,
    input  logic [DW-1:0]     load_wdata_i,
    output logic [CTRL_W-1:0] ctrl_rdata_o,
    output logic [DW-1:0]     load_rdata_o,
    output logic [DW-1:0]     count_o,
    output logic              zero_o,
    output logic              irq_en_o
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic            en_q, ie_q, per_q, running, tick;
    logic [PS_W-1:0] ps_q;
    logic [DW-1:0]   load_q, count_q;
    logic            wr_en, crst, ps_chg, en_chg, sw_evt, expire, done;
    logic            zero_q;

    // Software events that pre-empt a tick on the same edge
    assign wr_en  = ctrl_wdata_i[EN_BIT] & ~ctrl_wdata_i[CRST_BIT];
    assign crst   = ctrl_wr_i & ctrl_wdata_i[CRST_BIT];
    assign ps_chg = ctrl_wr_i & (ctrl_wdata_i[PS_W-1:0] != ps_q);
    assign en_chg = ctrl_wr_i & (wr_en != en_q);
    assign sw_evt = load_wr_i | crst | ps_chg | en_chg;

    assign expire = tick & (count_q <= ONE);
    assign done   = expire & ~per_q;

    dtmr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr_i),
        .wdata_i (ctrl_wdata_i),
        .done_i  (done),
        .act_i   (running),
        .en_o    (en_q),
        .ie_o    (ie_q),
        .per_o   (per_q),
        .ps_o    (ps_q),
        .rdata_o (ctrl_rdata_o)
    );

    dtmr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (ctrl_wr_i & wr_en),
        .stop_i    (ctrl_wr_i & ~wr_en),
        .done_i    (done),
        .running_o (running)
    );

    dtmr_prescaler #(.PSW(PS_W)) u_ps (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .clr_i  (sw_evt),
        .div_i  (ps_q),
        .tick_o (tick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            count_q <= '0;
            zero_q  <= 1'b0;
        end else begin
            zero_q <= expire;
            if (load_wr_i) begin
                load_q  <= load_wdata_i;
                count_q <= load_wdata_i;
            end else if (crst) begin
                count_q <= load_q;
            end else if (expire) begin
                count_q <= per_q ? load_q : '0;
            end else if (tick) begin
                count_q <= count_q - ONE;
            end
        end
    end

    assign load_rdata_o = load_q;
    assign count_o      = count_q;
    assign zero_o       = zero_q;
    assign irq_en_o     = ie_q;
endmodule

// File: rtl/dtmr_channel_chk.sv
module dtmr_channel_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctrl_wr_i,
    input logic [31:0]   ctrl_wdata_i,
    input logic          load_wr_i,
    input logic [DW-1:0] load_wdata_i,
    input logic [31:0]   ctrl_rdata_o,
    input logic [DW-1:0] load_rdata_o,
    input logic [DW-1:0] count_o,
    input logic          zero_o
);
    // R2
    act_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata_o[25] == ctrl_rdata_o[30]);

    // R3
    load_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> (count_o == $past(load_wdata_i)) && (load_rdata_o == $past(load_wdata_i)));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata_o[30] && !ctrl_wr_i && !load_wr_i && count_o > DW'(1))
        |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - DW'(1)));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !$past(ctrl_wr_i) && !ctrl_rdata_o[27]) |-> !ctrl_rdata_o[30]);

    // R7
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_rdata_o[30] && !ctrl_wr_i && !load_wr_i) |=> $stable(count_o));

    // R8
    crst_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_wdata_i[26] && !load_wr_i)
        |=> (count_o == $past(load_rdata_o)) && !ctrl_rdata_o[30]);
endmodule

bind dtmr_channel dtmr_channel_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr_i    (ctrl_wr_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .load_wr_i    (load_wr_i),
    .load_wdata_i (load_wdata_i),
    .ctrl_rdata_o (ctrl_rdata_o),
    .load_rdata_o (load_rdata_o),
    .count_o      (count_o),
    .zero_o       (zero_o)
);

// File: tb/dtmr_channel_bench.sv
`timescale 1ns/1ps
module dtmr_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        load_wr = 1'b0;
    logic [31:0] load_wdata = '0;
    logic [31:0] ctrl_rd, load_rd, count;
    logic        zero, irq_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 0;
    int exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dtmr_channel u_dtmr_channel (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
        .load_wr_i(load_wr), .load_wdata_i(load_wdata),
        .ctrl_rdata_o(ctrl_rd), .load_rdata_o(load_rd),
        .count_o(count), .zero_o(zero), .irq_en_o(irq_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(posedge clk); @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_load(input logic [31:0] v);
        load_wr = 1'b1; load_wdata = v;
        @(posedge clk); @(negedge clk);
        load_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Scoreboard monitor: expected expiry cycles against observed pulses (R4, R6)
    always @(negedge clk) begin
        if (rst_n) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                checks++; errors++;
                $display("FAIL R4 missed expiry actual=none expected=%0d", exp_q.pop_front());
            end
            if (zero) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected expiry actual=%0d expected=none", cyc);
                end else if (exp_q[0] != cyc) begin
                    errors++;
                    $display("FAIL R4 expiry cycle actual=%0d expected=%0d", cyc, exp_q[0]);
                    void'(exp_q.pop_front());
                end else begin
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        int c0;
        int c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", ctrl_rd, 32'h0000_0005, "ctrl reset");
        chk("R1", load_rd, 32'h0, "load reset");
        chk("R1", count, 32'h0, "count reset");
        chk("R1", {31'b0, zero}, 32'h0, "zero reset");

        // R2 reserved and active bits ignore writes
        wr_ctrl(32'h03FF_FF05);
        chk("R2", ctrl_rd, 32'h0000_0005, "reserved/act write");

        // R3 load reloads the counter
        wr_load(32'd3);
        chk("R3", count, 32'd3, "count after load");
        chk("R3", load_rd, 32'd3, "load readback");

        // R4 one-shot with prescale 5: ticks every 6 clocks
        wr_ctrl(32'h4000_0005);
        c0 = cyc;
        chk("R2", ctrl_rd, 32'h4200_0005, "active while running");
        exp_q.push_back(c0 + 18);
        wait_cyc(c0 + 6);
        chk("R4", count, 32'd2, "count after first tick");
        wait_cyc(c0 + 20);
        chk("R5", ctrl_rd, 32'h0000_0005, "one-shot clears enable/active");
        chk("R5", count, 32'd0, "one-shot count");

        // R6 periodic, prescale 2, count 4, interrupt enabled
        wr_load(32'd4);
        wr_ctrl(32'h6800_0002);
        c0 = cyc;
        chk("R10", {31'b0, irq_en}, 32'h1, "irq enable out");
        chk("R10", ctrl_rd, 32'h6A00_0002, "periodic readback");
        exp_q.push_back(c0 + 12);
        exp_q.push_back(c0 + 24);
        exp_q.push_back(c0 + 36);
        wait_cyc(c0 + 39);
        wr_ctrl(32'h0800_0002);
        // R7 freeze
        chk("R7", count, 32'd3, "frozen count");
        chk("R7", ctrl_rd, 32'h0800_0002, "disabled readback");
        chk("R10", {31'b0, irq_en}, 32'h0, "irq enable cleared");
        repeat (10) @(negedge clk);
        chk("R7", count, 32'd3, "count stable while idle");

        // R7 resume, then R9 prescale change
        wr_ctrl(32'h4800_0002);
        c1 = cyc;
        exp_q.push_back(c1 + 9);
        wait_cyc(c1 + 10);
        wr_ctrl(32'h4800_0000);
        chk("R9", count, 32'd4, "count kept across prescale change");
        exp_q.push_back(c1 + 15);
        wait_cyc(c1 + 16);
        wr_ctrl(32'h0800_0000);

        // R8 counter reset overrides enable
        wr_load(32'd20);
        wr_ctrl(32'h4000_0000);
        c0 = cyc;
        wait_cyc(c0 + 5);
        chk("R4", count, 32'd15, "prescale 0 decrement");
        wr_ctrl(32'h4400_0000);
        chk("R8", count, 32'd20, "counter reset reload");
        chk("R8", ctrl_rd, 32'h0000_0000, "enable dropped, reset self-clears");
        repeat (5) @(negedge clk);
        chk("R8", count, 32'd20, "stays stopped after reset");

        // R11 load write on the expiry edge
        wr_load(32'd5);
        wr_ctrl(32'h4000_0000);
        c0 = cyc;
        wait_cyc(c0 + 4);
        chk("R4", count, 32'd1, "count before collision");
        wr_load(32'd7);
        chk("R11", count, 32'd7, "load wins over tick");
        chk("R11", ctrl_rd, 32'h4200_0000, "still running");
        exp_q.push_back(c0 + 12);
        wait_cyc(c0 + 14);
        chk("R5", ctrl_rd, 32'h0000_0000, "stopped after expiry");

        repeat (3) @(negedge clk);
        chk("R6", exp_q.size(), 32'd0, "all expected expiries seen");
        done_flag = 1;
        finish_run();
    end
endmodule